// File: doc/BRIEF.md
# Clock Group Stop Gate

This block takes a free-running source clock and drives a group of gated copies of it. Another clock domain or a power manager can turn the group off with an active-low stop request. The request may change at any moment relative to the source clock. The block therefore passes it through a two-flop synchronizer before it acts on it.

The gate enable changes only while the source clock is low. As a result, a stopped group always rests at logic low, and a restarted group always begins with a complete high phase. No output ever shows a shortened pulse.

Each time the group is enabled, after reset or after a restart, it must deliver a minimum number of pulses before a new stop can take effect. A stop request that arrives during that interval is remembered. It is carried out as soon as the interval ends, even if the request has been withdrawn in the meantime. A status output reports when the group is parked. An ungated copy of the source clock is also provided for loads that must never stop.

Top module: `clk_group_gate`

## Requirements
- R1: A stop request (`stop_req_n` = 0) that arrives after the minimum interval has been served takes effect after exactly three further output pulses. These are the pulses at the first, second and third rising source edges after the request goes low.
- R2: While the group is parked, every `clk_out` bit stays at logic 0 for the whole source period.
- R3: After `stop_req_n` returns to 1, the first output pulse occurs at the fourth rising source edge after the release. Every output pulse lasts one full high phase of the source clock (half a period).
- R4: After reset and after every restart, at least `MIN_ON` output pulses are delivered before a stop takes effect. When a stop request is already waiting, exactly `MIN_ON` pulses are delivered.
- R5: A stop request seen during the minimum interval is held pending. It parks the group when the interval ends, even if it was withdrawn earlier. If the request is no longer present at that point, the group restarts after exactly one missing pulse.
- R6: `parked` is 1 exactly in the source periods that carry no output pulse after reset. It rises at the first rising edge with the output already low, and it falls at the rising edge that starts the first full pulse.
- R7: While `rst` is 1, the group runs ungated, `parked` is 0 and `stop_req_n` is ignored. The minimum-interval count restarts from zero when reset is released.
- R8: `clk_free` keeps toggling while the group is parked.
- R9: All bits of `clk_out` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Free-running source clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req_n | input | 1 | Asynchronous stop request, active low |
| clk_out | output | GROUP_W | Gated clock group |
| clk_free | output | 1 | Ungated copy of the source clock |
| parked | output | 1 | High while the group is held low |

## Verification
The risky overlap is a stop request that lands while the minimum-interval counter is still running. The stop and the restart then fall on adjacent edges, and the parked flag is high for a single cycle only. The bench raises the request for two cycles shortly after a restart and then withdraws it. It expects a run of exactly `MIN_ON` pulses, one missing pulse, and then uninterrupted running. These expectations are judged by splitting the observed output into runs and gaps, with every pulse width measured and the parked flag compared each cycle.

// File: rtl/clk_group_gate_pkg.sv
`timescale 1ns/1ps
package clk_group_gate_pkg;

    typedef enum logic {
        GS_RUN    = 1'b0,
        GS_PARKED = 1'b1
    } gate_state_e;

    typedef struct packed {
        gate_state_e st;
        logic        pend;
    } ctrl_flags_t;

    function automatic int cnt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/clk_group_stop_sync.sv
`timescale 1ns/1ps
module clk_group_stop_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_n_async,
    output logic stop_req
);
    logic [SYNC_STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[SYNC_STAGES-2:0], stop_n_async};
    end

    assign stop_req = ~sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/clk_group_stop_ctrl.sv
`timescale 1ns/1ps
module clk_group_stop_ctrl
    import clk_group_gate_pkg::*;
#(
    parameter int MIN_ON = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    output logic run_en
);
    localparam int CW = cnt_bits(MIN_ON);
    localparam logic [CW-1:0] LAST = CW'(MIN_ON - 1);

    ctrl_flags_t    fl_q;
    logic [CW-1:0]  cnt_q;
    logic           done;

    assign done = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q.st   <= GS_RUN;
            fl_q.pend <= 1'b0;
            cnt_q     <= '0;
        end else begin
            unique case (fl_q.st)
                GS_RUN: begin
                    if (!done) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (stop_req) fl_q.pend <= 1'b1;
                    end else if (stop_req || fl_q.pend) begin
                        fl_q.st   <= GS_PARKED;
                        fl_q.pend <= 1'b0;
                    end
                end
                GS_PARKED: begin
                    if (!stop_req) begin
                        fl_q.st <= GS_RUN;
                        cnt_q   <= '0;
                    end
                end
                default: fl_q.st <= GS_RUN;
            endcase
        end
    end

    assign run_en = (fl_q.st == GS_RUN);
endmodule

// File: rtl/clk_group_gate_bank.sv
`timescale 1ns/1ps
module clk_group_gate_bank #(
    parameter int GROUP_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    output logic               en_q,
    output logic               parked,
    output logic [GROUP_W-1:0] clk_out
);
    // enable moves only while clk is low
    always_ff @(negedge clk) begin
        if (rst) en_q <= 1'b1;
        else     en_q <= run_en;
    end

    always_ff @(posedge clk) begin
        if (rst) parked <= 1'b0;
        else     parked <= ~en_q;
    end

    for (genvar gi = 0; gi < GROUP_W; gi++) begin : g_out
        assign clk_out[gi] = clk & en_q;
    end
endmodule

// File: rtl/clk_group_gate.sv
`timescale 1ns/1ps
module clk_group_gate #(
    parameter int GROUP_W     = 3,
    parameter int MIN_ON      = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_src,
    input  logic               rst,
    input  logic               stop_req_n,
    output logic [GROUP_W-1:0] clk_out,
    output logic               clk_free,
    output logic               parked
);
    logic stop_req;
    logic run_en;
    logic gate_en;

    clk_group_stop_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk_src),
        .rst          (rst),
        .stop_n_async (stop_req_n),
        .stop_req     (stop_req)
    );

    clk_group_stop_ctrl #(.MIN_ON(MIN_ON)) u_ctrl (
        .clk      (clk_src),
        .rst      (rst),
        .stop_req (stop_req),
        .run_en   (run_en)
    );

    clk_group_gate_bank #(.GROUP_W(GROUP_W)) u_bank (
        .clk     (clk_src),
        .rst     (rst),
        .run_en  (run_en),
        .en_q    (gate_en),
        .parked  (parked),
        .clk_out (clk_out)
    );

    assign clk_free = clk_src;
endmodule

// File: rtl/clk_group_gate_chk.sv
`timescale 1ns/1ps
module clk_group_gate_chk #(
    parameter int MIN_ON = 100
) (
    input logic clk,
    input logic rst,
    input logic stop_n,
    input logic parked,
    input logic gate_en
);
    localparam int OCW = $clog2(MIN_ON + 1);

    logic [OCW-1:0] on_cnt;

    always_ff @(posedge clk) begin
        if (rst || !gate_en)            on_cnt <= '0;
        else if (on_cnt < OCW'(MIN_ON)) on_cnt <= on_cnt + 1'b1;
    end

    AST_MIN_ON_SERVED: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_en) |-> (on_cnt >= OCW'(MIN_ON)));                 // R4

    AST_RESTART_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_en) |-> $past(stop_n, 3));                         // R3

    AST_PARK_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(parked) |-> ($past(gate_en, 2) && !$past(gate_en)));    // R6

    AST_RESET_RUNS: assert property (@(posedge clk)
        rst |=> (gate_en && !parked));                                // R7
endmodule

bind clk_group_gate clk_group_gate_chk #(.MIN_ON(MIN_ON)) u_chk (
    .clk     (clk_src),
    .rst     (rst),
    .stop_n  (stop_req_n),
    .parked  (parked),
    .gate_en (gate_en)
);

// File: tb/clk_group_gate_test.sv
`timescale 1ns/1ps
module clk_group_gate_test;
    localparam int GW     = 4;
    localparam int MIN_ON = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stop_n = 1'b1;
    logic [GW-1:0] clk_out;
    logic          clk_free;
    logic          parked;

    always #5 clk = ~clk;

    clk_group_gate #(.GROUP_W(GW), .MIN_ON(MIN_ON)) uut (
        .clk_src    (clk),
        .rst        (rst),
        .stop_req_n (stop_n),
        .clk_out    (clk_out),
        .clk_free   (clk_free),
        .parked     (parked)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit    lvl;
        int    len;
        string req;
    } seg_t;
    seg_t exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_seg(input bit lvl, input int len, input string req);
        exp_q.push_back('{lvl, len, req});
    endtask

    // monitor: splits the output into runs of pulses and gaps
    bit cur_lvl;
    int cur_len = 0;
    bit started = 0;
    always @(posedge clk) begin : mon
        logic lvl;
        seg_t e;
        #1;
        if (!rst) begin
            lvl = clk_out[0];
            check(clk_out == '0 || clk_out == '1, "R9", "group bits differ",
                  int'(clk_out), 0);
            check(parked == !lvl, "R6", "parked vs pulse", int'(parked), int'(!lvl));
            if (!started) begin
                started = 1;
                cur_lvl = lvl;
                cur_len = 1;
            end else if (lvl == cur_lvl) begin
                cur_len++;
            end else begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected segment length", cur_len, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.lvl == cur_lvl, e.req, "segment level", int'(cur_lvl), int'(e.lvl));
                    check(e.len == cur_len, e.req, "segment length", cur_len, e.len);
                end
                cur_lvl = lvl;
                cur_len = 1;
            end
        end
    end

    // pulse width: every high phase must be a full 5 ns
    realtime t_rise = 0.0;
    int      bad_width = 0;
    int      n_pulses = 0;
    always @(posedge clk_out[0]) t_rise = $realtime;
    always @(negedge clk_out[0]) begin
        if (!rst) begin
            n_pulses++;
            if ($realtime - t_rise != 5.0) begin
                bad_width++;
                $display("FAIL R3 pulse width: actual %0t expected 5ns", $realtime - t_rise);
            end
        end
    end

    int free_while_parked = 0;
    always @(posedge clk_free) if (parked && !rst) free_while_parked++;

    initial begin
        // R7: reset runs ungated and ignores a low request
        stop_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(clk_out == '1, "R7", "clk_out high phase in reset", int'(clk_out), (1 << GW) - 1);
        check(parked == 1'b0, "R7", "parked in reset", int'(parked), 0);
        @(negedge clk);
        #1;
        check(clk_out == '0, "R7", "clk_out low phase in reset", int'(clk_out), 0);

        // R4/R7: request pending at release -> exactly MIN_ON pulses
        expect_seg(1'b1, MIN_ON, "R4");
        @(negedge clk);
        #1 rst = 1'b0;
        wait (parked);
        expect_seg(1'b0, 23, "R3");
        repeat (20) @(negedge clk);
        #1 stop_n = 1'b1;

        // R1: late request, three more pulses
        wait (!parked);
        expect_seg(1'b1, 33, "R1");
        repeat (30) @(negedge clk);
        #1 stop_n = 1'b0;
        wait (parked);
        expect_seg(1'b0, 8, "R3");
        repeat (5) @(negedge clk);
        #1 stop_n = 1'b1;

        // R5: short request inside the interval stays pending
        wait (!parked);
        expect_seg(1'b1, MIN_ON, "R5");
        expect_seg(1'b0, 1, "R5");
        repeat (2) @(negedge clk);
        #1 stop_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 stop_n = 1'b1;
        wait (parked);
        wait (!parked);

        // R1 again, then hold parked
        expect_seg(1'b1, 33, "R1");
        repeat (30) @(negedge clk);
        #1 stop_n = 1'b0;
        wait (parked);
        repeat (20) begin
            @(posedge clk);
            #1 check(clk_out == '0, "R2", "output while parked", int'(clk_out), 0);
            @(negedge clk);
            #1 check(clk_out == '0, "R2", "output low phase parked", int'(clk_out), 0);
        end

        check(exp_q.size() == 0, "R4", "missing segments", exp_q.size(), 0);
        check(bad_width == 0, "R3", "short pulses", bad_width, 0);
        check(n_pulses > 0, "R3", "pulses seen", n_pulses, 1);
        check(free_while_parked > 20, "R8", "free clock edges while parked",
              free_while_parked, 21);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "R4", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule